// File: doc/BRIEF.md
# Two-Wire Bus Pin Override for Recovery

This block sits between a two-wire bus controller and the open-drain pads for the clock and data lines. In controller mode the controller's drive-low requests go straight to the pad output enables. Software can write one mode bit to take over both pins. It can then pulse the clock line by hand to free a target device that is holding data low.

While software owns the pins, it picks a direction for each pin. It changes the output latches only through a write-one-to-set register and a write-one-to-clear register. It reads the live line levels through a two-flop synchroniser. The pads are always open-drain. An output enable of 1 pulls the line low, and the pad output value is tied low outside this block. Register reads are combinational from the current address. Register writes take effect at the clock edge where the write enable is high.

Top module: `bus_pin_override`

## Requirements
- R1: After reset the mode bit is 0, both direction bits are 0, both output latches are 1, and the synchronised pin levels read 1.
- R2: When the mode bit (offset 0x48, bit 0) is 0, each pad output enable equals the controller's drive-low request for that pin, with the clock pin on `padSclOe` and the data pin on `padSdaOe`.
- R3: The direction register at offset 0x4C reads back what was written. Bit 0 sets the clock pin as an output and bit 1 sets the data pin as an output.
- R4: Writing to offset 0x58 sets each latch whose write-data bit is 1 (bit 0 clock, bit 1 data). Zero bits and bits above 1 leave the latches unchanged.
- R5: Writing to offset 0x5C clears each latch whose write-data bit is 1. Zero bits leave the latches unchanged.
- R6: When the mode bit is 1, a pad output enable is 1 only when that pin's direction bit is 1 and its latch is 0. Otherwise the line is released.
- R7: Reading offset 0x54 returns the latches in bits 1:0 (bit 0 clock, bit 1 data) and zero above.
- R8: Reading offset 0x50 returns the pad input levels (bit 0 clock, bit 1 data). The levels pass through two flops, so a change at the pad becomes readable after the second rising clock edge.
- R9: Changing the mode bit leaves the latches unchanged. Set and clear writes made in controller mode update the latches without affecting the pads.
- R10: Writes to the read-only level register (0x50) change no state. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W | Register byte offset for reads and writes |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Combinational read data for the addressed register |
| ctlSclLow | input | 1 | Controller request to pull the clock line low |
| ctlSdaLow | input | 1 | Controller request to pull the data line low |
| padSclIn | input | 1 | Live clock line level from the pad |
| padSdaIn | input | 1 | Live data line level from the pad |
| padSclOe | output | 1 | Clock pad output enable (1 pulls the line low) |
| padSdaOe | output | 1 | Data pad output enable (1 pulls the line low) |

## Verification
The synchroniser properties assume that the pad inputs sit at the idle-high level while reset is applied. After reset is released, the first stage is expected to hold the pad level from the edge before. The bench holds both pads high across every reset, including the one in the middle of the run. It moves the pad lines only at falling clock edges, well away from any reset. The latch properties assume that a write to the set or clear offset is a single-cycle strobe. The bench drops the write enable on the falling edge that follows each write.

// File: rtl/bpo_pkg.sv
`timescale 1ns/1ps
package bpo_pkg;
  localparam int PIN_N = 2;  // bit 0 clock line, bit 1 data line

  localparam int OFS_MODE  = 'h48;
  localparam int OFS_DIR   = 'h4C;
  localparam int OFS_PINS  = 'h50;
  localparam int OFS_LATCH = 'h54;
  localparam int OFS_SET   = 'h58;
  localparam int OFS_CLR   = 'h5C;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MODE,
    RD_DIR,
    RD_PINS,
    RD_LATCH
  } rdSel_t;

  typedef struct packed {
    logic   modeWr;
    logic   dirWr;
    logic   setWr;
    logic   clrWr;
    rdSel_t rdSel;
  } bpoStrobe_t;
endpackage

// File: rtl/bpo_ctrl.sv
`timescale 1ns/1ps
module bpo_ctrl
  import bpo_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output bpoStrobe_t        strb
);
  logic hitMode, hitDir, hitPins, hitLatch, hitSet, hitClr;

  always_comb begin
    hitMode  = (regAddr == ADDR_W'(OFS_MODE));
    hitDir   = (regAddr == ADDR_W'(OFS_DIR));
    hitPins  = (regAddr == ADDR_W'(OFS_PINS));
    hitLatch = (regAddr == ADDR_W'(OFS_LATCH));
    hitSet   = (regAddr == ADDR_W'(OFS_SET));
    hitClr   = (regAddr == ADDR_W'(OFS_CLR));
  end

  always_comb begin
    strb        = '0;
    strb.modeWr = regWrEn && hitMode;
    strb.dirWr  = regWrEn && hitDir;
    strb.setWr  = regWrEn && hitSet;
    strb.clrWr  = regWrEn && hitClr;
    if (hitMode)       strb.rdSel = RD_MODE;
    else if (hitDir)   strb.rdSel = RD_DIR;
    else if (hitPins)  strb.rdSel = RD_PINS;
    else if (hitLatch) strb.rdSel = RD_LATCH;
    else               strb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/bpo_datapath.sv
`timescale 1ns/1ps
module bpo_datapath
  import bpo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PN     = PIN_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpoStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PN-1:0]     pinIn,
  input  logic [PN-1:0]     ctlLow,
  output logic [DATA_W-1:0] rdData,
  output logic [PN-1:0]     pinOe
);
  localparam int PAD_W = DATA_W - PN;

  logic          modeQ;
  logic [PN-1:0] dirQ;
  logic [PN-1:0] latchQ;
  logic [PN-1:0] latchNext;
  logic [PN-1:0] setBits, clrBits;
  logic [PN-1:0] sync1Q, sync2Q;
  logic          unusedWdata;

  assign unusedWdata = ^wrData[DATA_W-1:PN];

  always_comb begin
    setBits   = strb.setWr ? wrData[PN-1:0] : '0;
    clrBits   = strb.clrWr ? wrData[PN-1:0] : '0;
    latchNext = (latchQ | setBits) & ~clrBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= 1'b0;
      dirQ   <= '0;
      latchQ <= '1;
    end else begin
      if (strb.modeWr) modeQ <= wrData[0];
      if (strb.dirWr)  dirQ  <= wrData[PN-1:0];
      latchQ <= latchNext;
    end
  end

  for (genvar p = 0; p < PN; p++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sync1Q[p] <= 1'b1;
        sync2Q[p] <= 1'b1;
      end else begin
        sync1Q[p] <= pinIn[p];
        sync2Q[p] <= sync1Q[p];
      end
    end

    always_comb begin
      if (modeQ) pinOe[p] = dirQ[p] & ~latchQ[p];
      else       pinOe[p] = ctlLow[p];
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_MODE:  rdData = {{(DATA_W-1){1'b0}}, modeQ};
      RD_DIR:   rdData = {{PAD_W{1'b0}}, dirQ};
      RD_PINS:  rdData = {{PAD_W{1'b0}}, sync2Q};
      RD_LATCH: rdData = {{PAD_W{1'b0}}, latchQ};
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/bus_pin_override.sv
`timescale 1ns/1ps
module bus_pin_override
  import bpo_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              ctlSclLow,
  input  logic              ctlSdaLow,
  input  logic              padSclIn,
  input  logic              padSdaIn,
  output logic              padSclOe,
  output logic              padSdaOe
);
  bpoStrobe_t       strb;
  logic [PIN_N-1:0] pinOe;

  bpo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  bpo_datapath #(.DATA_W(DATA_W), .PN(PIN_N)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (regWrData),
    .pinIn  ({padSdaIn, padSclIn}),
    .ctlLow ({ctlSdaLow, ctlSclLow}),
    .rdData (regRdData),
    .pinOe  (pinOe)
  );

  assign padSclOe = pinOe[0];
  assign padSdaOe = pinOe[1];
endmodule

// File: rtl/bpo_chk.sv
`timescale 1ns/1ps
module bpo_chk
  import bpo_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic              ctlSclLow,
  input logic              ctlSdaLow,
  input logic              padSclIn,
  input logic              padSdaIn,
  input logic              padSclOe,
  input logic              padSdaOe,
  input logic              modeQ,
  input logic [PIN_N-1:0]  dirQ,
  input logic [PIN_N-1:0]  latchQ,
  input logic [PIN_N-1:0]  sync1Q,
  input logic [PIN_N-1:0]  sync2Q
);
  // R4
  set_raises_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(OFS_SET) && regWrData[1]) |=> latchQ[1]);

  // R5
  clr_lowers_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(OFS_CLR) && regWrData[0]) |=> !latchQ[0]);

  // R2
  ctl_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ |-> (padSclOe == ctlSclLow && padSdaOe == ctlSdaLow));

  // R6
  scl_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ && !(dirQ[0] && !latchQ[0])) |-> !padSclOe);

  // R6
  sda_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ && !(dirQ[1] && !latchQ[1])) |-> !padSdaOe);

  // R8
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> sync1Q == $past({padSdaIn, padSclIn}));

  // R8
  sync_second_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> sync2Q == $past(sync1Q));

  // R9
  mode_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(OFS_MODE)) |=> $stable(latchQ));

  // R10
  pins_readonly_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(OFS_PINS)) |=>
      ($stable(modeQ) && $stable(dirQ) && $stable(latchQ)));
endmodule

bind bus_pin_override bpo_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .ctlSclLow (ctlSclLow),
  .ctlSdaLow (ctlSdaLow),
  .padSclIn  (padSclIn),
  .padSdaIn  (padSdaIn),
  .padSclOe  (padSclOe),
  .padSdaOe  (padSdaOe),
  .modeQ     (u_dp.modeQ),
  .dirQ      (u_dp.dirQ),
  .latchQ    (u_dp.latchQ),
  .sync1Q    (u_dp.sync1Q),
  .sync2Q    (u_dp.sync2Q)
);

// File: tb/bus_pin_override_tb.sv
`timescale 1ns/1ps
module bus_pin_override_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NV = 18;

  localparam logic [7:0] A_MODE = 8'h48, A_DIR = 8'h4C, A_PINS = 8'h50,
                         A_LAT  = 8'h54, A_SET = 8'h58, A_CLR  = 8'h5C;

  typedef struct packed {
    logic        we;
    logic [7:0]  wa;
    logic [15:0] wd;
    logic [1:0]  ctl;   // {sda, scl}
    logic [7:0]  ra;
    logic [15:0] exp;
    logic [1:0]  oe;    // {sda, scl}
    logic [7:0]  rq;
  } vec_t;

  function automatic vec_t mk(logic we, logic [7:0] wa, logic [15:0] wd,
                              logic [1:0] ctl, logic [7:0] ra,
                              logic [15:0] exp, logic [1:0] oe, logic [7:0] rq);
    vec_t v;
    v.we = we; v.wa = wa; v.wd = wd; v.ctl = ctl;
    v.ra = ra; v.exp = exp; v.oe = oe; v.rq = rq;
    return v;
  endfunction

  localparam vec_t VEC [NV] = '{
    mk(1'b0, 8'h00,  16'h0000, 2'b00, A_LAT,  16'h3, 2'b00, 8'd7),  // R7 latches idle high
    mk(1'b0, 8'h00,  16'h0000, 2'b01, A_MODE, 16'h0, 2'b01, 8'd2),  // R2 clock follows controller
    mk(1'b0, 8'h00,  16'h0000, 2'b10, A_DIR,  16'h0, 2'b10, 8'd2),  // R2 data follows controller
    mk(1'b1, A_CLR,  16'h0003, 2'b11, A_LAT,  16'h0, 2'b11, 8'd9),  // R9 clear in controller mode
    mk(1'b1, A_MODE, 16'h0001, 2'b11, A_LAT,  16'h0, 2'b00, 8'd6),  // R6 inputs released
    mk(1'b1, A_DIR,  16'h0001, 2'b11, A_DIR,  16'h1, 2'b01, 8'd3),  // R3 clock output
    mk(1'b1, A_DIR,  16'h0002, 2'b00, A_DIR,  16'h2, 2'b10, 8'd3),  // R3 data output
    mk(1'b1, A_DIR,  16'h0003, 2'b00, A_MODE, 16'h1, 2'b11, 8'd6),  // R6 both low
    mk(1'b1, A_SET,  16'h0001, 2'b00, A_LAT,  16'h1, 2'b10, 8'd4),  // R4 set clock
    mk(1'b1, A_SET,  16'h0000, 2'b00, A_LAT,  16'h1, 2'b10, 8'd4),  // R4 zero bits
    mk(1'b1, A_CLR,  16'h0000, 2'b00, A_LAT,  16'h1, 2'b10, 8'd5),  // R5 zero bits
    mk(1'b1, A_SET,  16'h0002, 2'b00, A_LAT,  16'h3, 2'b00, 8'd4),  // R4 set data
    mk(1'b1, A_CLR,  16'h0002, 2'b00, A_LAT,  16'h1, 2'b10, 8'd5),  // R5 clear data
    mk(1'b1, A_SET,  16'hFFFC, 2'b00, A_LAT,  16'h1, 2'b10, 8'd4),  // R4 upper bits ignored
    mk(1'b1, A_PINS, 16'h0000, 2'b00, A_DIR,  16'h3, 2'b10, 8'd10), // R10 read-only write
    mk(1'b1, A_MODE, 16'h0000, 2'b01, A_LAT,  16'h1, 2'b01, 8'd9),  // R9 back to controller
    mk(1'b0, 8'h00,  16'h0000, 2'b00, 8'h00,  16'h0, 2'b00, 8'd10), // R10 unmapped read
    mk(1'b0, 8'h00,  16'h0000, 2'b00, A_PINS, 16'h3, 2'b00, 8'd8)   // R8 idle levels
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic          ctlSclLow = 1'b0, ctlSdaLow = 1'b0;
  logic          padSclIn = 1'b1, padSdaIn = 1'b1;
  logic          padSclOe, padSdaOe;
  int            nChk = 0;
  int            nFail = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  bus_pin_override #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .ctlSclLow(ctlSclLow), .ctlSdaLow(ctlSdaLow),
    .padSclIn(padSclIn), .padSdaIn(padSdaIn),
    .padSclOe(padSclOe), .padSdaOe(padSdaOe)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic readChk(string req, logic [7:0] a, logic [15:0] exp);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    readChk("R1 mode", A_MODE, 16'h0);
    readChk("R1 dir", A_DIR, 16'h0);
    readChk("R1 latch", A_LAT, 16'h3);
    readChk("R1 pins", A_PINS, 16'h3);
    check("R1 oe", {14'd0, padSdaOe, padSclOe}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ctlSdaLow, ctlSclLow} = VEC[i].ctl;
      regAddr   = VEC[i].wa;
      regWrData = VEC[i].wd;
      regWrEn   = VEC[i].we;
      @(negedge clk);
      regWrEn = 1'b0;
      regAddr = VEC[i].ra;
      #1;
      check($sformatf("R%0d vector %0d read", VEC[i].rq, i), regRdData, VEC[i].exp);
      check($sformatf("R%0d vector %0d oe", VEC[i].rq, i),
            {14'd0, padSdaOe, padSclOe}, {14'd0, VEC[i].oe});
    end

    // R1 reset in the middle of a run: direction was 3, latch 1
    @(negedge clk);
    {ctlSdaLow, ctlSclLow} = 2'b00;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    readChk("R1 dir after reset", A_DIR, 16'h0);
    readChk("R1 latch after reset", A_LAT, 16'h3);
    readChk("R1 mode after reset", A_MODE, 16'h0);

    // R8 two-flop latency on the clock pin, then on the data pin
    regAddr = A_PINS;
    padSclIn = 1'b0;
    @(negedge clk);
    readChk("R8 clock after one edge", A_PINS, 16'h3);
    @(negedge clk);
    readChk("R8 clock after two edges", A_PINS, 16'h2);
    padSdaIn = 1'b0;
    @(negedge clk);
    readChk("R8 data after one edge", A_PINS, 16'h2);
    @(negedge clk);
    readChk("R8 data after two edges", A_PINS, 16'h0);
    padSclIn = 1'b1;
    padSdaIn = 1'b1;
    repeat (2) @(negedge clk);
    readChk("R8 lines released", A_PINS, 16'h3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule